// File: doc/BRIEF.md
# External Memory Non-Secure Window Filter

This block assigns a security attribute to every access aimed at a 128-Mbyte external memory. The memory is treated as 16384 blocks of 8 Kbyte each. A parameterised set of window registers (four by default) each name a first block and a block count. A block is non-secure when any window covers it. Every other block is secure. An access presented on the check port gets a registered verdict one clock later. The verdict reports whether the block is non-secure, whether the access may proceed, and whether it was an illegal non-secure attempt on secure space.

The window registers sit behind a small register port. Only secure requests can change or observe them. A length that would run past the last block is cut back when it is written, so a stored window never extends past the end of memory. The reset contents follow a global trust-enable input. With it high, all windows are empty and all memory is secure. With it low, the first window spans the whole memory.

Top module: `mem_nsec_filter`

## Requirements
- R1: With `tz_en` high during reset, every window reads back as zero after reset, and a non-secure access to any block is blocked.
- R2: With `tz_en` low during reset, window 0 reads back as start 0 and length 16384, the other windows read zero, and non-secure accesses anywhere in memory are allowed.
- R3: Block index `chk_addr[26:13]` is non-secure in window w exactly when the window's length is non-zero and start <= block < start + length. A length of 0 disables the window.
- R4: The non-secure area is the union of all windows. When window 0 covers start 0 and length 16384, every block is non-secure whatever the other windows hold.
- R5: A written length larger than 16384 minus the written start is stored as 16384 minus the start.
- R6: A register write with `reg_secure` high updates the window chosen by `reg_sel`. A write with `reg_secure` low leaves every window unchanged.
- R7: With `reg_secure` high, `reg_rdata` returns the selected window with the start in bits [13:0] and the length in bits [30:16], and zero elsewhere. With `reg_secure` low, `reg_rdata` is zero.
- R8: `res_valid` is high in the cycle after a cycle with `chk_valid` high and low otherwise. It is low directly after reset.
- R9: A secure check (`chk_secure` high) always gives `res_allow` high and `res_illegal` low.
- R10: A non-secure check of a secure block gives `res_allow` low and `res_illegal` high for that one result cycle. A non-secure check of a non-secure block is allowed.
- R11: A window of length 1 at block 16383 makes offsets 0x7FFE000 to 0x7FFFFFF non-secure and leaves offset 0x7FFDFFF secure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tz_en | input | 1 | Trust enable; selects the reset contents of the windows |
| reg_wr | input | 1 | Register write strobe |
| reg_secure | input | 1 | Register request is secure |
| reg_sel | input | 2 | Window index for read and write |
| reg_wdata | input | 32 | Write data: start [13:0], length [30:16] |
| reg_rdata | output | 32 | Read data of the selected window, zero for non-secure requests |
| chk_valid | input | 1 | Check request valid |
| chk_secure | input | 1 | Checked access is secure |
| chk_addr | input | 27 | Byte offset of the checked access |
| res_valid | output | 1 | Verdict valid, one clock after the request |
| res_nsec | output | 1 | Addressed block is non-secure |
| res_allow | output | 1 | Access may proceed |
| res_illegal | output | 1 | Non-secure access to a secure block |

## Verification
On every cycle, the assertions check the one-clock result timing, that secure checks always pass, that an illegal flag always comes with a blocked verdict on a secure block, that stored windows never reach past the end of memory, and that non-secure writes leave the windows untouched. Only the bench scenarios can show that the two reset contents are right, which blocks the window bounds and the union actually cover, and how lengths are clamped. The same holds for the last-block corner, for zero-length windows, and for the masking of non-secure reads.

// File: rtl/nsf_pkg.sv
package nsf_pkg;
   parameter int unsigned BLK_W = 14;
   parameter int unsigned OFS_W = 13;
   localparam int unsigned ADDR_W = BLK_W + OFS_W;
   localparam int unsigned LEN_W = BLK_W + 1;
   localparam int unsigned REG_W = 32;
   localparam int unsigned LEN_LSB = 16;
   localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(1) << BLK_W;

   typedef logic [BLK_W-1:0] blk_idx_t;
   typedef logic [LEN_W-1:0] blk_len_t;

   typedef struct packed {
      blk_idx_t start;
      blk_len_t len;
   } nsf_win_t;

   // saturate a length so the window ends at or before the last block
   function automatic blk_len_t clamp_len(blk_idx_t s, blk_len_t l);
      blk_len_t room;
      room = FULL_LEN - LEN_W'(s);
      return (l > room) ? room : l;
   endfunction
endpackage

// File: rtl/nsf_regbank.sv
module nsf_regbank
   import nsf_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4,
   localparam int unsigned SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            tz_en,
   input  logic                            wr_en,
   input  logic                            acc_secure,
   input  logic [SEL_W-1:0]                sel,
   input  logic [REG_W-1:0]                wdata,
   output logic [REG_W-1:0]                rdata,
   output nsf_win_t [NUM_WIN-1:0]          win
);
   blk_idx_t wr_start;
   blk_len_t wr_len;

   assign wr_start = wdata[BLK_W-1:0];
   assign wr_len   = clamp_len(wr_start, wdata[LEN_LSB +: LEN_W]);

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      nsf_win_t rst_val;
      assign rst_val = (w == 0 && !tz_en) ? '{start: '0, len: FULL_LEN} : '0;

      always_ff @(posedge clk) begin
         if (!rst_n)
            win[w] <= rst_val;
         else if (wr_en && acc_secure && sel == SEL_W'(w))
            win[w] <= '{start: wr_start, len: wr_len};
      end

      // R5
      clamp_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((LEN_W+1)'(win[w].start) + (LEN_W+1)'(win[w].len)) <= (LEN_W+1)'(FULL_LEN));

      // R6
      ns_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !acc_secure) |=> $stable(win[w]));
   end

   always_comb begin
      rdata = '0;
      for (int w = 0; w < NUM_WIN; w++) begin
         if (acc_secure && sel == SEL_W'(w)) begin
            rdata[BLK_W-1:0]       = win[w].start;
            rdata[LEN_LSB +: LEN_W] = win[w].len;
         end
      end
   end
endmodule

// File: rtl/nsf_match.sv
module nsf_match
   import nsf_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4
) (
   input  nsf_win_t [NUM_WIN-1:0] win,
   input  blk_idx_t               blk,
   output logic [NUM_WIN-1:0]     hit,
   output logic                   any_hit
);
   localparam int unsigned CMP_W = LEN_W + 1;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
      logic [CMP_W-1:0] win_end;
      assign win_end = CMP_W'(win[w].start) + CMP_W'(win[w].len);
      assign hit[w]  = (win[w].len != '0)
                       && (blk >= win[w].start)
                       && (CMP_W'(blk) < win_end);
   end

   assign any_hit = |hit;
endmodule

// File: rtl/mem_nsec_filter.sv
module mem_nsec_filter
   import nsf_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4,
   localparam int unsigned SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tz_en,
   input  logic              reg_wr,
   input  logic              reg_secure,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              chk_valid,
   input  logic              chk_secure,
   input  logic [ADDR_W-1:0] chk_addr,
   output logic              res_valid,
   output logic              res_nsec,
   output logic              res_allow,
   output logic              res_illegal
);
   if (NUM_WIN < 1 || NUM_WIN > 16) begin : g_bad_win
      $error("mem_nsec_filter: NUM_WIN must be 1..16");
   end
   if (LEN_LSB < BLK_W || LEN_LSB + LEN_W > REG_W) begin : g_bad_fields
      $error("mem_nsec_filter: register fields do not fit");
   end

   nsf_win_t [NUM_WIN-1:0] win;
   logic [NUM_WIN-1:0]     hit;
   logic                   any_hit;
   blk_idx_t               blk;

   assign blk = chk_addr[ADDR_W-1 -: BLK_W];

   nsf_regbank #(.NUM_WIN(NUM_WIN)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .tz_en      (tz_en),
      .wr_en      (reg_wr),
      .acc_secure (reg_secure),
      .sel        (reg_sel),
      .wdata      (reg_wdata),
      .rdata      (reg_rdata),
      .win        (win)
   );

   nsf_match #(.NUM_WIN(NUM_WIN)) u_match (
      .win     (win),
      .blk     (blk),
      .hit     (hit),
      .any_hit (any_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_nsec    <= 1'b0;
         res_allow   <= 1'b0;
         res_illegal <= 1'b0;
      end else begin
         res_valid   <= chk_valid;
         res_nsec    <= chk_valid && any_hit;
         res_allow   <= chk_valid && (chk_secure || any_hit);
         res_illegal <= chk_valid && !chk_secure && !any_hit;
      end
   end

   // R8
   res_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |=> res_valid);

   // R8
   res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |=> !res_valid);

   // R9
   secure_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && chk_secure) |=> (res_allow && !res_illegal));

   // R10
   illegal_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_illegal |-> (res_valid && !res_allow && !res_nsec));
endmodule

// File: tb/sim_mem_nsec_filter.sv
module sim_mem_nsec_filter;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tz_en = 1'b1;
   logic        reg_wr = 1'b0;
   logic        reg_secure = 1'b0;
   logic [1:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        chk_valid = 1'b0;
   logic        chk_secure = 1'b0;
   logic [26:0] chk_addr = '0;
   logic        res_valid, res_nsec, res_allow, res_illegal;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   mem_nsec_filter u0 (
      .clk(clk), .rst_n(rst_n), .tz_en(tz_en),
      .reg_wr(reg_wr), .reg_secure(reg_secure), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .chk_valid(chk_valid), .chk_secure(chk_secure), .chk_addr(chk_addr),
      .res_valid(res_valid), .res_nsec(res_nsec), .res_allow(res_allow),
      .res_illegal(res_illegal)
   );

   task automatic ck(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [26:0] baddr(int blk, int ofs);
      return {blk[13:0], ofs[12:0]};
   endfunction

   task automatic do_reset(logic tz);
      @(negedge clk);
      rst_n = 1'b0; tz_en = tz;
      reg_wr = 1'b0; chk_valid = 1'b0;
      repeat (2) @(negedge clk);
      ck("R8 reset res_valid", 32'(res_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(int sel, int start, int len, logic sec);
      @(negedge clk);
      reg_sel = sel[1:0]; reg_secure = sec;
      reg_wdata = (32'(len) << 16) | 32'(start);
      reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(string tag, int sel, logic sec, int start, int len);
      @(negedge clk);
      reg_sel = sel[1:0]; reg_secure = sec;
      #1;
      ck(tag, reg_rdata, (32'(len) << 16) | 32'(start));
   endtask

   task automatic acc(string tag, logic [26:0] a, logic sec, logic exp_ns);
      logic exp_allow;
      exp_allow = sec || exp_ns;
      @(negedge clk);
      chk_addr = a; chk_secure = sec; chk_valid = 1'b1;
      #1;
      ck({tag, " R8 before edge"}, 32'(res_valid), 0);
      @(negedge clk);
      chk_valid = 1'b0;
      ck({tag, " R8 valid"}, 32'(res_valid), 1);
      ck({tag, " nsec"}, 32'(res_nsec), 32'(exp_ns));
      ck({tag, " allow"}, 32'(res_allow), 32'(exp_allow));
      ck({tag, " illegal"}, 32'(res_illegal), 32'(!exp_allow));
      @(negedge clk);
      ck({tag, " R10 pulse end"}, 32'(res_illegal), 0);
      ck({tag, " R8 drop"}, 32'(res_valid), 0);
   endtask

   task automatic t_reset_secure();
      do_reset(1'b1);
      for (int w = 0; w < 4; w++) rd("R1 window zero", w, 1'b1, 0, 0);
      acc("R1 ns blocked low", baddr(0, 0), 1'b0, 1'b0);
      acc("R1 ns blocked high", baddr(16383, 8191), 1'b0, 1'b0);
   endtask

   task automatic t_reset_open();
      do_reset(1'b0);
      rd("R2 window0 full", 0, 1'b1, 0, 16384);
      rd("R2 window3 zero", 3, 1'b1, 0, 0);
      acc("R2 ns allowed top", baddr(16383, 8191), 1'b0, 1'b1);
      wr(1, 5, 3, 1'b1);
      acc("R4 full window dominates", baddr(9000, 4), 1'b0, 1'b1);
   endtask

   task automatic t_windows();
      do_reset(1'b1);
      wr(0, 10, 5, 1'b1);
      wr(2, 100, 1, 1'b1);
      acc("R3 below start", baddr(9, 8191), 1'b0, 1'b0);
      acc("R3 at start", baddr(10, 0), 1'b0, 1'b1);
      acc("R3 last inside", baddr(14, 8191), 1'b0, 1'b1);
      acc("R3 past end", baddr(15, 0), 1'b0, 1'b0);
      acc("R4 second window", baddr(100, 77), 1'b0, 1'b1);
      acc("R4 gap", baddr(101, 0), 1'b0, 1'b0);
      wr(2, 100, 0, 1'b1);
      acc("R3 zero length", baddr(100, 77), 1'b0, 1'b0);
   endtask

   task automatic t_clamp();
      wr(3, 16380, 100, 1'b1);
      rd("R5 clamp near end", 3, 1'b1, 16380, 4);
      wr(1, 0, 32767, 1'b1);
      rd("R5 clamp oversize", 1, 1'b1, 0, 16384);
      wr(1, 0, 0, 1'b1);
      rd("R6 secure write", 1, 1'b1, 0, 0);
   endtask

   task automatic t_last_block();
      wr(3, 16383, 1, 1'b1);
      acc("R11 last block start", 27'h7FFE000, 1'b0, 1'b1);
      acc("R11 last byte", 27'h7FFFFFF, 1'b0, 1'b1);
      acc("R11 just below", 27'h7FFDFFF, 1'b0, 1'b0);
   endtask

   task automatic t_ns_access();
      wr(0, 2000, 50, 1'b0);
      rd("R6 ns write ignored", 0, 1'b1, 10, 5);
      acc("R6 ns write no effect", baddr(2000, 0), 1'b0, 1'b0);
      rd("R7 ns read zero", 0, 1'b0, 0, 0);
   endtask

   task automatic t_secure_pass();
      acc("R9 secure on secure", baddr(500, 3), 1'b1, 1'b0);
      acc("R9 secure on nonsecure", baddr(12, 3), 1'b1, 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset_secure();
      t_reset_open();
      t_windows();
      t_clamp();
      t_last_block();
      t_ns_access();
      t_secure_pass();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule